// File: doc/BRIEF.md
# Graphics Memory Window Router

This block sits between a host byte bus and the memory-side resources of a 2D graphics controller. It takes each host byte access and sends it to the frame-buffer RAM, to the accelerator's register port, or to the accelerator's host-data port. It can also answer the access itself with a fixed value.

Host accesses arrive through one of two address spaces. The legacy space is a 128 KB window. A control bit can take its top 256 bytes and turn them into a register window for the accelerator. The linear space is an aperture of 1 MB or 2 MB. Its enable and base address come from a control register. While the accelerator is in host-data mode, host byte writes are not stored in memory. Instead they are collected into 32-bit words and pushed to the accelerator.

A small state machine sequences the accesses:
- ST_IDLE accepts a request. Writes complete in that cycle.
- A read moves to one of three response states for one cycle, then returns to ST_IDLE:
  - ST_RD_VRAM returns RAM data.
  - ST_RD_ACC returns accelerator register data.
  - ST_RD_CONST returns a value the block produces itself.
- `host_ready` is high only in ST_IDLE. `host_rvalid` is high in any of the three read states.

Top module: `gfx_mem_router`

## Requirements
- R1: After reset, the control registers read back as follows: index 0x20 gives 0x00, index 0x21 gives 0x00 and index 0x2A gives 0x03. This means the register window and the aperture are both off.
- R2: With bit 4 of control register 0x20 clear, a legacy-space access at any offset goes to VRAM at that offset. Offsets 0x1FF00 and above are included.
- R3: With bit 4 of register 0x20 set, a legacy write at offset 0x1FF00+L is handled by its local offset L:
  - If L is 0x20 or above, the write goes to the accelerator register port at address L-0x20 with the same data.
  - If L is below 0x20, the write reaches neither the accelerator nor VRAM.
- R4: A register-window read returns a value that depends on its local offset:
  - At exactly L=0x20, it returns 0x20 while `acc_busy` is high and 0x00 otherwise.
  - At L below 0x20, it returns 0x00.
  - The data is valid (`host_rvalid`) one cycle after the request.
- R5: A register-window read at L above 0x20 returns the accelerator register at address L-0x20.
- R6: While `hostdata_mode` is high, a byte write outside the register window is stored in a 32-bit holding word and never reaches VRAM. The byte lands in bits [31-8n:24-8n], where n is the address modulo 4.
- R7: A packed write to lane 3 raises `push_valid` for exactly one cycle, starting the cycle after that write, with `push_data` holding the assembled word. Lanes not written since the previous push keep their old bytes.
- R8: In register 0x21, the control bits define the aperture:
  - Bit 5 enables the aperture.
  - Bits 7:6 give address bits 25:24 of the base.
  - Bits 3:0 give address bits 23:20 of the base.
  - Bit 4 set selects a 2 MB aperture; clear selects 1 MB.
  A hit goes to VRAM at the address minus the base.
- R9: A linear access that is disabled or outside the aperture is answered by the block itself: a read returns 0xFF and a write is dropped.
- R10: Linear VRAM addresses wrap modulo the VRAM size of 2^VRAM_AW bytes.
- R11: Routing follows a fixed priority:
  - Register-window decode beats host-data packing.
  - Packing beats an ordinary legacy-window VRAM write.
- R12: Control registers 0x20, 0x21 and 0x2A are written with a one-cycle `cfg_we` strobe. They read back combinationally through `cfg_idx`. Any other index reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_space | input | 1 | 0 = legacy window offset, 1 = linear physical address |
| host_addr | input | AP_AW | Legacy offset (low LEG_AW bits) or linear address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Router idle, request accepted this cycle |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 8 | Read byte |
| vram_req | output | 1 | VRAM access strobe |
| vram_we | output | 1 | VRAM write enable |
| vram_addr | output | VRAM_AW | VRAM byte address |
| vram_wdata | output | 8 | VRAM write byte |
| vram_rdata | input | 8 | VRAM read byte, valid the cycle after vram_req |
| acc_req | output | 1 | Accelerator register strobe |
| acc_we | output | 1 | Accelerator register write enable |
| acc_addr | output | ACC_AW | Accelerator register address |
| acc_wdata | output | 8 | Accelerator register write byte |
| acc_rdata | input | 8 | Accelerator register read byte, valid the cycle after acc_req |
| acc_busy | input | 1 | Accelerator busy flag |
| hostdata_mode | input | 1 | Accelerator expects host data words |
| push_valid | output | 1 | One-cycle push of an assembled word |
| push_data | output | 32 | Assembled data word |
| cfg_we | input | 1 | Control register write strobe |
| cfg_idx | input | 8 | Control register index |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |

## Verification
The assertions check, on every cycle:
- that read data appears only one cycle after an accepted read;
- that a push follows only a lane-3 write made in host-data mode;
- that no VRAM write happens while host-data mode is on;
- that accelerator writes come only from the legacy register window at local offsets 0x20 and above;
- that a disabled aperture never routes to VRAM.

Only the bench's scenarios can show the following:
- the exact data paths: lane placement, retention of old lanes, the busy code, and aperture base and size decode;
- the wrap of linear addresses;
- the reset values of the control registers.

// File: rtl/gmr_pkg.sv
package gmr_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_VRAM,
        TGT_ACC,
        TGT_BUSY,
        TGT_ZERO,
        TGT_ONES,
        TGT_PACK
    } gmr_target_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_VRAM,
        ST_RD_ACC,
        ST_RD_CONST
    } gmr_state_e;

    localparam logic [7:0] IDX_WINCTL  = 8'h20;
    localparam logic [7:0] IDX_APERCTL = 8'h21;
    localparam logic [7:0] IDX_BUSCTL  = 8'h2A;

    localparam logic [7:0] RST_WINCTL  = 8'h00;
    localparam logic [7:0] RST_APERCTL = 8'h00;
    localparam logic [7:0] RST_BUSCTL  = 8'h03;

    localparam int WINCTL_EN_BIT  = 4;
    localparam int APER_EN_BIT    = 5;
    localparam int APER_2MB_BIT   = 4;

    localparam logic [7:0] REGWIN_ACC_START = 8'h20;
    localparam logic [7:0] BUSY_CODE        = 8'h20;

endpackage

// File: rtl/gmr_cfg_regs.sv
module gmr_cfg_regs
    import gmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_idx,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic [7:0] winctl,
    output logic [7:0] aperctl
);

    logic [7:0] busctl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            winctl  <= RST_WINCTL;
            aperctl <= RST_APERCTL;
            busctl  <= RST_BUSCTL;
        end else if (cfg_we) begin
            unique case (cfg_idx)
                IDX_WINCTL:  winctl  <= cfg_wdata;
                IDX_APERCTL: aperctl <= cfg_wdata;
                IDX_BUSCTL:  busctl  <= cfg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (cfg_idx)
            IDX_WINCTL:  cfg_rdata = winctl;
            IDX_APERCTL: cfg_rdata = aperctl;
            IDX_BUSCTL:  cfg_rdata = busctl;
            default:     cfg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/gmr_decode.sv
module gmr_decode
    import gmr_pkg::*;
#(
    parameter int AP_AW   = 26,
    parameter int LEG_AW  = 17,
    parameter int VRAM_AW = 20,
    parameter int ACC_AW  = 8
) (
    input  logic               space,
    input  logic               we,
    input  logic [AP_AW-1:0]   addr,
    input  logic               hostdata_mode,
    input  logic [7:0]         winctl,
    input  logic [7:0]         aperctl,
    output gmr_target_e        tgt,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic [ACC_AW-1:0]  acc_addr
);

    localparam logic [LEG_AW-1:0] REGWIN_BASE = {{(LEG_AW-8){1'b1}}, 8'h00};
    localparam int APER_UNIT_BIT = 20;

    logic [LEG_AW-1:0] leg_off;
    logic [7:0]        loc;
    logic              in_regwin;
    logic [AP_AW-1:0]  ap_base;
    logic [AP_AW-1:0]  ap_rel;
    logic              ap_hit;

    assign leg_off   = addr[LEG_AW-1:0];
    assign loc       = leg_off[7:0];
    assign in_regwin = winctl[WINCTL_EN_BIT] && (leg_off >= REGWIN_BASE);

    assign ap_base = AP_AW'({aperctl[7:6], aperctl[3:0]}) << APER_UNIT_BIT;
    assign ap_rel  = addr - ap_base;
    assign ap_hit  = aperctl[APER_EN_BIT]
                   && (ap_rel[AP_AW-1:APER_UNIT_BIT+1] == '0)
                   && (aperctl[APER_2MB_BIT] || !ap_rel[APER_UNIT_BIT]);

    always_comb begin
        tgt       = TGT_NONE;
        vram_addr = '0;
        acc_addr  = ACC_AW'(loc - REGWIN_ACC_START);
        if (!space) begin
            if (in_regwin) begin
                if (we)
                    tgt = (loc >= REGWIN_ACC_START) ? TGT_ACC : TGT_NONE;
                else if (loc == REGWIN_ACC_START)
                    tgt = TGT_BUSY;
                else
                    tgt = (loc > REGWIN_ACC_START) ? TGT_ACC : TGT_ZERO;
            end else if (we && hostdata_mode) begin
                tgt = TGT_PACK;
            end else begin
                tgt       = TGT_VRAM;
                vram_addr = VRAM_AW'(leg_off);
            end
        end else begin
            if (!ap_hit)
                tgt = we ? TGT_NONE : TGT_ONES;
            else if (we && hostdata_mode)
                tgt = TGT_PACK;
            else begin
                tgt       = TGT_VRAM;
                vram_addr = ap_rel[VRAM_AW-1:0];
            end
        end
    end

    always_comb begin
        if (space && !aperctl[APER_EN_BIT])
            assert_aperture_off_quiet_R9: assert (tgt == TGT_NONE || tgt == TGT_ONES);
    end

endmodule

// File: rtl/gmr_packer.sv
module gmr_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack_we,
    input  logic [1:0]        lane,
    input  logic [7:0]        byte_in,
    output logic              push_valid,
    output logic [WORD_W-1:0] push_data
);

    localparam int LANES = WORD_W / 8;

    logic [WORD_W-1:0] word_q;
    logic              push_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            push_q <= 1'b0;
        end else begin
            push_q <= pack_we && (int'(lane) == LANES - 1);
            if (pack_we)
                word_q[WORD_W-1-8*int'(lane) -: 8] <= byte_in;
        end
    end

    assign push_valid = push_q;
    assign push_data  = word_q;

endmodule

// File: rtl/gfx_mem_router.sv
module gfx_mem_router
    import gmr_pkg::*;
#(
    parameter int AP_AW   = 26,
    parameter int LEG_AW  = 17,
    parameter int VRAM_AW = 20,
    parameter int ACC_AW  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic               host_space,
    input  logic [AP_AW-1:0]   host_addr,
    input  logic [7:0]         host_wdata,
    output logic               host_ready,
    output logic               host_rvalid,
    output logic [7:0]         host_rdata,
    output logic               vram_req,
    output logic               vram_we,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic [7:0]         vram_wdata,
    input  logic [7:0]         vram_rdata,
    output logic               acc_req,
    output logic               acc_we,
    output logic [ACC_AW-1:0]  acc_addr,
    output logic [7:0]         acc_wdata,
    input  logic [7:0]         acc_rdata,
    input  logic               acc_busy,
    input  logic               hostdata_mode,
    output logic               push_valid,
    output logic [31:0]        push_data,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_idx,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata
);

    logic [7:0]         winctl;
    logic [7:0]         aperctl;
    gmr_target_e        tgt;
    logic [VRAM_AW-1:0] dec_vram_addr;
    logic [ACC_AW-1:0]  dec_acc_addr;
    gmr_state_e         state_q, state_d;
    logic [7:0]         const_q, const_d;
    logic               accept;
    logic               pack_we;

    gmr_cfg_regs i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .winctl    (winctl),
        .aperctl   (aperctl)
    );

    gmr_decode #(
        .AP_AW   (AP_AW),
        .LEG_AW  (LEG_AW),
        .VRAM_AW (VRAM_AW),
        .ACC_AW  (ACC_AW)
    ) i_dec (
        .space         (host_space),
        .we            (host_we),
        .addr          (host_addr),
        .hostdata_mode (hostdata_mode),
        .winctl        (winctl),
        .aperctl       (aperctl),
        .tgt           (tgt),
        .vram_addr     (dec_vram_addr),
        .acc_addr      (dec_acc_addr)
    );

    gmr_packer #(.WORD_W(32)) i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pack_we    (pack_we),
        .lane       (host_addr[1:0]),
        .byte_in    (host_wdata),
        .push_valid (push_valid),
        .push_data  (push_data)
    );

    assign accept = (state_q == ST_IDLE) && host_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            const_q <= 8'h00;
        end else begin
            state_q <= state_d;
            const_q <= const_d;
        end
    end

    // Next state and constant response
    always_comb begin
        state_d = ST_IDLE;
        const_d = const_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !host_we) begin
                    unique case (tgt)
                        TGT_VRAM: state_d = ST_RD_VRAM;
                        TGT_ACC:  state_d = ST_RD_ACC;
                        TGT_BUSY: begin state_d = ST_RD_CONST; const_d = acc_busy ? BUSY_CODE : 8'h00; end
                        TGT_ONES: begin state_d = ST_RD_CONST; const_d = 8'hFF; end
                        TGT_ZERO: begin state_d = ST_RD_CONST; const_d = 8'h00; end
                        default:  begin state_d = ST_RD_CONST; const_d = 8'h00; end
                    endcase
                end
            end
            ST_RD_VRAM, ST_RD_ACC, ST_RD_CONST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        host_ready  = (state_q == ST_IDLE);
        host_rvalid = (state_q != ST_IDLE);
        vram_req    = accept && (tgt == TGT_VRAM);
        vram_we     = host_we;
        vram_addr   = dec_vram_addr;
        vram_wdata  = host_wdata;
        acc_req     = accept && (tgt == TGT_ACC);
        acc_we      = host_we;
        acc_addr    = dec_acc_addr;
        acc_wdata   = host_wdata;
        pack_we     = accept && host_we && (tgt == TGT_PACK);
        unique case (state_q)
            ST_RD_VRAM:  host_rdata = vram_rdata;
            ST_RD_ACC:   host_rdata = acc_rdata;
            ST_RD_CONST: host_rdata = const_q;
            default:     host_rdata = 8'h00;
        endcase
    end

    assert_rvalid_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_req && !host_we && host_ready));

    assert_push_after_lane3_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(host_req && host_we && host_ready && hostdata_mode
                             && host_addr[1:0] == 2'd3));

    assert_no_vram_write_packing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_req && vram_we) |-> !hostdata_mode);

    assert_acc_write_from_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_we) |-> (!host_space && host_addr[7:0] >= REGWIN_ACC_START));

    assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(vram_req && acc_req));

endmodule

// File: tb/test_gfx_mem_router.sv
module test_gfx_mem_router;

    localparam int AP_AW   = 26;
    localparam int VRAM_AW = 20;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_req = 1'b0, host_we = 1'b0, host_space = 1'b0;
    logic [AP_AW-1:0]   host_addr = '0;
    logic [7:0]         host_wdata = '0;
    logic               host_ready, host_rvalid;
    logic [7:0]         host_rdata;
    logic               vram_req, vram_we;
    logic [VRAM_AW-1:0] vram_addr;
    logic [7:0]         vram_wdata;
    logic [7:0]         vram_rdata = '0;
    logic               acc_req, acc_we;
    logic [7:0]         acc_addr, acc_wdata;
    logic [7:0]         acc_rdata = '0;
    logic               acc_busy = 1'b0, hostdata_mode = 1'b0;
    logic               push_valid;
    logic [31:0]        push_data;
    logic               cfg_we = 1'b0;
    logic [7:0]         cfg_idx = '0, cfg_wdata = '0;
    logic [7:0]         cfg_rdata;

    int n_chk = 0, n_bad = 0;
    int vram_wr_cnt = 0, acc_wr_cnt = 0, push_cnt = 0;
    logic [VRAM_AW-1:0] last_vaddr;
    logic [7:0]         last_vdata, last_aaddr, last_adata;
    logic [31:0]        last_push;

    always #5 clk = ~clk;

    gfx_mem_router #(.AP_AW(AP_AW), .VRAM_AW(VRAM_AW)) i_gfx_mem_router (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_space(host_space),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .vram_req(vram_req), .vram_we(vram_we), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
        .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_busy(acc_busy), .hostdata_mode(hostdata_mode),
        .push_valid(push_valid), .push_data(push_data),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [7:0] vram_pat(input logic [VRAM_AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Memory and accelerator models plus strobe monitors
    always @(posedge clk) begin
        if (vram_req && !vram_we) vram_rdata <= vram_pat(vram_addr);
        if (vram_req && vram_we) begin
            vram_wr_cnt <= vram_wr_cnt + 1; last_vaddr <= vram_addr; last_vdata <= vram_wdata;
        end
        if (acc_req && !acc_we) acc_rdata <= acc_addr ^ 8'hC3;
        if (acc_req && acc_we) begin
            acc_wr_cnt <= acc_wr_cnt + 1; last_aaddr <= acc_addr; last_adata <= acc_wdata;
        end
        if (push_valid) begin
            push_cnt <= push_cnt + 1; last_push <= push_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] idx, output logic [7:0] d);
        @(negedge clk); cfg_idx = idx; #1; d = cfg_rdata;
    endtask

    task automatic hwrite(input logic sp, input logic [AP_AW-1:0] a, input logic [7:0] d);
        @(negedge clk); host_req = 1'b1; host_we = 1'b1; host_space = sp; host_addr = a; host_wdata = d;
        @(negedge clk); host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(input logic sp, input logic [AP_AW-1:0] a, output logic [7:0] d);
        @(negedge clk); host_req = 1'b1; host_we = 1'b0; host_space = sp; host_addr = a;
        @(negedge clk); host_req = 1'b0;
        d = host_rvalid ? host_rdata : 8'hXX;
    endtask

    typedef struct packed {
        logic             space;
        logic [AP_AW-1:0] addr;
        logic [7:0]       exp;
    } rd_vec_t;

    // Window on (0x20 = 0x10), aperture 1 MB at 0x500000 (0x21 = 0x25), busy low
    localparam rd_vec_t RD_TABLE [9] = '{
        '{1'b0, 26'h0000123, 8'h78},   // R2 legacy below window
        '{1'b0, 26'h001FF20, 8'h00},   // R4 idle status
        '{1'b0, 26'h001FF10, 8'h00},   // R4 below 0x20
        '{1'b0, 26'h001FF25, 8'hC6},   // R5 accel reg 0x05
        '{1'b0, 26'h001FEFF, 8'h5B},   // R2 just below window
        '{1'b1, 26'h0500010, 8'h4A},   // R8 aperture hit
        '{1'b1, 26'h04FFFFF, 8'hFF},   // R9 below base
        '{1'b1, 26'h0600000, 8'hFF},   // R9 past 1 MB
        '{1'b1, 26'h05ABCDE, 8'h38}    // R8 aperture hit high
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int v0, a0, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_read(8'h20, d); check("R1 idx20", d, 8'h00);
        cfg_read(8'h21, d); check("R1 idx21", d, 8'h00);
        cfg_read(8'h2A, d); check("R1 idx2A", d, 8'h03);
        check("R1 ready", host_ready, 1'b1);
        hread(1'b1, 26'h0000000, d); check("R1 R9 aperture off read", d, 8'hFF);

        // R2 window disabled: top offsets reach VRAM
        hread(1'b0, 26'h001FF40, d); check("R2 top offset vram", d, 8'hE5);

        // R12 config writes
        cfg_write(8'h20, 8'h10); cfg_read(8'h20, d); check("R12 idx20", d, 8'h10);
        cfg_write(8'h21, 8'h25); cfg_read(8'h21, d); check("R12 idx21", d, 8'h25);
        cfg_read(8'h33, d); check("R12 unknown idx", d, 8'h00);

        foreach (RD_TABLE[i]) begin
            hread(RD_TABLE[i].space, RD_TABLE[i].addr, d);
            check($sformatf("R2/R4/R5/R8/R9 vector %0d", i), d, RD_TABLE[i].exp);
        end

        // R4 busy status
        acc_busy = 1'b1;
        hread(1'b0, 26'h001FF20, d); check("R4 busy code", d, 8'h20);
        acc_busy = 1'b0;

        // R3 window writes
        a0 = acc_wr_cnt; v0 = vram_wr_cnt;
        hwrite(1'b0, 26'h001FF30, 8'h77); @(negedge clk);
        check("R3 acc write count", acc_wr_cnt - a0, 1);
        check("R3 acc addr", last_aaddr, 8'h10);
        check("R3 acc data", last_adata, 8'h77);
        hwrite(1'b0, 26'h001FF05, 8'h99); @(negedge clk);
        check("R3 low write dropped acc", acc_wr_cnt - a0, 1);
        check("R3 low write dropped vram", vram_wr_cnt - v0, 0);

        // R6 / R7 packing
        hostdata_mode = 1'b1;
        v0 = vram_wr_cnt; p0 = push_cnt;
        hwrite(1'b0, 26'h0000100, 8'h11);
        hwrite(1'b0, 26'h0000101, 8'h22);
        hwrite(1'b0, 26'h0000102, 8'h33);
        check("R7 no early push", push_cnt - p0, 0);
        hwrite(1'b0, 26'h0000103, 8'h44); @(negedge clk);
        check("R7 push count", push_cnt - p0, 1);
        check("R6 lane order", last_push, 32'h11223344);
        check("R6 no vram write", vram_wr_cnt - v0, 0);
        hwrite(1'b1, 26'h0500005, 8'h55);
        hwrite(1'b1, 26'h0500007, 8'h66); @(negedge clk);
        check("R7 retained lanes", last_push, 32'h11553366);
        check("R7 single pulse", push_cnt - p0, 2);

        // R11 window beats packing
        a0 = acc_wr_cnt;
        hwrite(1'b0, 26'h001FF24, 8'hAB); @(negedge clk);
        check("R11 window wins acc", acc_wr_cnt - a0, 1);
        check("R11 window wins addr", last_aaddr, 8'h04);
        hwrite(1'b0, 26'h0000003, 8'h01); @(negedge clk);
        check("R11 packing untouched by window write", last_push, 32'h11553301);
        check("R11 no vram while packing", vram_wr_cnt - v0, 0);
        hostdata_mode = 1'b0;

        // R11 packing off: legacy write to VRAM
        hwrite(1'b0, 26'h0000042, 8'h3C); @(negedge clk);
        check("R11 legacy vram addr", last_vaddr, 20'h00042);

        // R8 / R10 2 MB aperture with wrap
        cfg_write(8'h21, 8'h35);
        hwrite(1'b1, 26'h06ABCDE, 8'h5D); @(negedge clk);
        check("R10 wrap addr", last_vaddr, 20'hABCDE);
        check("R8 2MB data", last_vdata, 8'h5D);

        // R9 disabled aperture write dropped, read 0xFF
        cfg_write(8'h21, 8'h15);
        v0 = vram_wr_cnt;
        hwrite(1'b1, 26'h0500000, 8'hEE); @(negedge clk);
        check("R9 write dropped", vram_wr_cnt - v0, 0);
        hread(1'b1, 26'h0500000, d); check("R9 read ones", d, 8'hFF);

        // R8 high base bits
        cfg_write(8'h21, 8'hE0);
        hread(1'b1, 26'h3000011, d); check("R8 base bits 25:24", d, 8'h4B);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule